// File: doc/BRIEF.md
# Flash Programming Mode Entry Guard

This block decides when the chip may switch into a privileged flash programming mode that is driven entirely from the serial slave port. Software on the serial side unlocks the mode by writing two fixed key values to two guard registers, one after the other. At the moment the second key lands, the block samples a set of qualifying inputs: a debug-enable flag, a preboot flag, a supply-good flag and a 4-bit unlock field. The mode is entered only if every one of them is in its required state.

Once entered, the mode is sticky. Only a hard reset clears it, either from the external reset pin or from the watchdog. While the mode is active the block halts the processor core and turns off the serial interrupts that the processor would service. It also publishes which flash operations are allowed. The secure flag, captured at entry, cuts the allowed set down to mass erase alone.

Writes that come from the processor side never reach the guard registers. They cannot arm, complete or abort the key sequence.

Top module: `flash_prog_guard`

## Requirements
- R1: While a hard reset is applied and after it ends, mode_active=0, cpu_halt=0, serial_irq_en=1, all three permission outputs are 0, and the key sequence is idle.
- R2: The mode is entered by a serial write (wr_src=1) of 8'hA5 to address 8'hC0, followed by a serial write of 8'h5A to address 8'hC1 as the very next serial write. mode_active rises in the cycle after the edge that takes the second write. Cycles with no write between the two keys are allowed.
- R3: While armed, any serial write other than the correct second key returns the sequence to idle. This covers wrong data, a wrong address, a repeat of the first key, and a second key written while the qualifiers fail. A later second key alone does not enter the mode. While idle, a serial write that is not the first key leaves the sequence idle.
- R4: Writes with wr_src=0 (processor side) have no effect on the key sequence or on the mode, whatever their address or data.
- R5: Entry additionally requires dbg_en=1, preboot=0, unlock=4'b0010 and supply_ok=1, all sampled only at the edge that takes the second key. Their values at other times, including after entry, have no effect.
- R6: Once active, the mode stays active through any writes and input changes. Only ext_rst_n=0 or wdog_rst=1 clears it.
- R7: cpu_halt=1 and serial_irq_en=0 exactly while the mode is active; otherwise cpu_halt=0 and serial_irq_en=1.
- R8: If secure=1 at the entry edge, then while the mode is active perm_mass_erase=1 and perm_read=perm_write=0. If secure=0 at entry, all three are 1. Later changes of secure have no effect.
- R9: All permission outputs are 0 whenever the mode is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous |
| wdog_rst | input | 1 | Watchdog reset request, active high, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_src | input | 1 | Write source: 1 = serial port, 0 = processor |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| dbg_en | input | 1 | Debug-enable flag (also holds the watchdog off) |
| preboot | input | 1 | Preboot flag; must be 0 for the secure flag to be valid |
| secure | input | 1 | Secure flag |
| unlock | input | 4 | Unlock field |
| supply_ok | input | 1 | System supply above its programming threshold |
| mode_active | output | 1 | Flash programming mode active |
| cpu_halt | output | 1 | Halt request to the processor core |
| serial_irq_en | output | 1 | Processor-serviced serial interrupts enabled |
| perm_read | output | 1 | Flash read-back permitted |
| perm_write | output | 1 | Flash write permitted |
| perm_mass_erase | output | 1 | Flash mass erase permitted |

## Verification
The hardest situation to reach from the ports is an armed sequence that gets broken in a way that is not obvious. Examples are a correct second key rejected only because one qualifier is off, a first key repeated, or processor writes slipped between the two keys. To reach each of these, the stimulus arms the guard and then applies exactly one disturbing write. It then completes the sequence with a correct second key and shows that entry happens only where the rules allow it. Qualifiers are also made bad while the first key is written and good at the second, to show that only the final write's sample matters.

// File: rtl/flash_prog_guard.sv
module flash_prog_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int UNLOCK_W = 4,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'hC0,
  parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'hC1,
  parameter logic [DATA_W-1:0] KEY_A_VAL = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_B_VAL = 8'h5A,
  parameter logic [UNLOCK_W-1:0] UNLOCK_CODE = 4'b0010
) (
  input  logic                clk,
  input  logic                ext_rst_n,
  input  logic                wdog_rst,
  input  logic                wr_en,
  input  logic                wr_src,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                dbg_en,
  input  logic                preboot,
  input  logic                secure,
  input  logic [UNLOCK_W-1:0] unlock,
  input  logic                supply_ok,
  output logic                mode_active,
  output logic                cpu_halt,
  output logic                serial_irq_en,
  output logic                perm_read,
  output logic                perm_write,
  output logic                perm_mass_erase
);

  logic hard_rst, ser_wr, hit_a, hit_b, qualified;
  logic armed, active, sec_q;

  assign hard_rst  = !ext_rst_n || wdog_rst;
  assign ser_wr    = wr_en && wr_src;
  assign hit_a     = (wr_addr == KEY_A_ADDR) && (wr_data == KEY_A_VAL);
  assign hit_b     = (wr_addr == KEY_B_ADDR) && (wr_data == KEY_B_VAL);
  assign qualified = dbg_en && !preboot && (unlock == UNLOCK_CODE) && supply_ok;

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      armed  <= 1'b0;
      active <= 1'b0;
      sec_q  <= 1'b0;
    end else if (!active && ser_wr) begin
      if (armed && hit_b && qualified) begin
        active <= 1'b1;
        sec_q  <= secure;
        armed  <= 1'b0;
      end else begin
        armed <= !armed && hit_a;
      end
    end
  end

  assign mode_active     = active;
  assign cpu_halt        = active;
  assign serial_irq_en   = !active;
  assign perm_mass_erase = active;
  assign perm_read       = active && !sec_q;
  assign perm_write      = active && !sec_q;

  // entry only from an armed sequence completed by a serial second key
  assert_entry_seq_R2: assert property (@(posedge clk) disable iff (hard_rst)
    $rose(active) |-> $past(armed) && $past(wr_en) && $past(wr_src)
                      && $past(wr_addr) == KEY_B_ADDR && $past(wr_data) == KEY_B_VAL);

  assert_entry_qual_R5: assert property (@(posedge clk) disable iff (hard_rst)
    $rose(active) |-> $past(dbg_en) && !$past(preboot)
                      && $past(unlock) == UNLOCK_CODE && $past(supply_ok));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (hard_rst)
    active |=> active);

  assert_cpu_ignored_R4: assert property (@(posedge clk) disable iff (hard_rst)
    (wr_en && !wr_src) |=> $stable(armed) && $stable(active));

  assert_abort_R3: assert property (@(posedge clk) disable iff (hard_rst)
    (armed && ser_wr && !hit_b) |=> !armed && !active);

  assert_secure_perm_R8: assert property (@(posedge clk) disable iff (hard_rst)
    (active && $past(active) && $past(perm_read) == 1'b0) |-> !perm_read && !perm_write);

  assert_idle_perm_R9: assert property (@(posedge clk) disable iff (hard_rst)
    !active |-> !perm_read && !perm_write && !perm_mass_erase);

  assert_halt_R7: assert property (@(posedge clk) disable iff (hard_rst)
    $rose(cpu_halt) |-> $fell(serial_irq_en));

endmodule

// File: tb/tb_flash_prog_guard.sv
module tb_flash_prog_guard;
  logic clk = 1'b0;
  logic ext_rst_n = 1'b0, wdog_rst = 1'b0;
  logic wr_en = 1'b0, wr_src = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic dbg_en = 1'b0, preboot = 1'b1, secure = 1'b0, supply_ok = 1'b0;
  logic [3:0] unlock = 4'h0;
  logic mode_active, cpu_halt, serial_irq_en, perm_read, perm_write, perm_mass_erase;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit m_arm = 1'b0, m_act = 1'b0, m_sec = 1'b0;

  always #5 clk = ~clk;

  flash_prog_guard dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdog_rst(wdog_rst),
    .wr_en(wr_en), .wr_src(wr_src), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_en(dbg_en), .preboot(preboot), .secure(secure), .unlock(unlock),
    .supply_ok(supply_ok), .mode_active(mode_active), .cpu_halt(cpu_halt),
    .serial_irq_en(serial_irq_en), .perm_read(perm_read), .perm_write(perm_write),
    .perm_mass_erase(perm_mass_erase));

  // behavioural reference model
  always @(posedge clk) begin
    if (!ext_rst_n || wdog_rst) begin
      m_arm = 1'b0; m_act = 1'b0; m_sec = 1'b0;
    end else if (!m_act && wr_en && wr_src) begin
      if (m_arm && wr_addr == 8'hC1 && wr_data == 8'h5A && dbg_en && !preboot
          && unlock == 4'b0010 && supply_ok) begin
        m_act = 1'b1; m_sec = secure; m_arm = 1'b0;
      end else begin
        m_arm = !m_arm && wr_addr == 8'hC0 && wr_data == 8'hA5;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) if (!done) begin
    chk(mode_active, m_act, "R2 mode_active vs model");
    chk(cpu_halt, m_act, "R7 cpu_halt vs model");
    chk(serial_irq_en, !m_act, "R7 serial_irq_en vs model");
    chk(perm_mass_erase, m_act, "R8/R9 perm_mass_erase vs model");
    chk(perm_read, m_act && !m_sec, "R8/R9 perm_read vs model");
    chk(perm_write, m_act && !m_sec, "R8/R9 perm_write vs model");
  end

  task automatic wr(input logic src, input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_src = src; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_src = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qual_ok();
    dbg_en = 1'b1; preboot = 1'b0; unlock = 4'b0010; supply_ok = 1'b1;
  endtask

  task automatic pin_reset();
    ext_rst_n = 1'b0; idle(2); ext_rst_n = 1'b1; idle(1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R1 reset state
    chk(mode_active, 1'b0, "R1 mode after reset");
    chk(serial_irq_en, 1'b1, "R1 irq enable after reset");
    chk(perm_mass_erase, 1'b0, "R1 perms after reset");
    ext_rst_n = 1'b1; idle(1);
    chk(mode_active, 1'b0, "R1 mode after reset release");

    // R2 normal entry, non-secure, with a gap between keys
    qual_ok(); secure = 1'b0;
    wr(1, 8'hC0, 8'hA5);
    chk(mode_active, 1'b0, "R2 not active after first key");
    idle(3);
    wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b1, "R2 active after second key");
    chk(perm_read, 1'b1, "R8 read allowed non-secure");
    chk(cpu_halt, 1'b1, "R7 halt while active");
    // R5/R6 qualifier changes and writes after entry
    dbg_en = 1'b0; supply_ok = 1'b0; preboot = 1'b1; unlock = 4'hF; secure = 1'b1;
    wr(1, 8'h10, 8'h00); wr(0, 8'hC0, 8'hA5); idle(2);
    chk(mode_active, 1'b1, "R6 stays active through writes/inputs");
    chk(perm_write, 1'b1, "R8 secure change after entry ignored");
    // R6 watchdog exit
    wdog_rst = 1'b1; idle(1); wdog_rst = 1'b0; idle(1);
    chk(mode_active, 1'b0, "R6 watchdog reset exits mode");
    chk(perm_mass_erase, 1'b0, "R9 perms cleared after exit");

    // R5 each qualifier failing in turn
    for (int k = 0; k < 4; k++) begin
      qual_ok(); secure = 1'b0;
      wr(1, 8'hC0, 8'hA5);
      case (k)
        0: dbg_en = 1'b0;
        1: preboot = 1'b1;
        2: unlock = 4'b0011;
        default: supply_ok = 1'b0;
      endcase
      wr(1, 8'hC1, 8'h5A);
      chk(mode_active, 1'b0, "R5 entry blocked by failing qualifier");
      qual_ok();
      wr(1, 8'hC1, 8'h5A);
      chk(mode_active, 1'b0, "R3 failed second key aborted sequence");
    end

    // R3 abort patterns
    wr(1, 8'hC0, 8'hA5); wr(1, 8'hC1, 8'h5B); wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b0, "R3 wrong data aborts");
    wr(1, 8'hC0, 8'hA5); wr(1, 8'hC0, 8'hA5); wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b0, "R3 repeated first key aborts");
    wr(1, 8'hC0, 8'hA5); wr(1, 8'h33, 8'h5A); wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b0, "R3 other address aborts");
    wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b0, "R3 second key alone from idle");
    wr(1, 8'hC0, 8'hA4); wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b0, "R3 wrong first key does not arm");

    // R4 processor writes ignored
    wr(0, 8'hC0, 8'hA5); wr(0, 8'hC1, 8'h5A);
    chk(mode_active, 1'b0, "R4 processor keys do nothing");
    wr(1, 8'hC0, 8'hA5); wr(0, 8'h33, 8'h00); wr(0, 8'hC0, 8'hA5); wr(0, 8'hC1, 8'h11);
    wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b1, "R4 processor writes between keys ignored");
    pin_reset();
    chk(mode_active, 1'b0, "R6 pin reset exits mode");

    // R5 qualifiers sampled only at final key; secure entry R8
    dbg_en = 1'b0; preboot = 1'b1; unlock = 4'h0; supply_ok = 1'b0; secure = 1'b0;
    wr(1, 8'hC0, 8'hA5);
    qual_ok(); secure = 1'b1;
    wr(1, 8'hC1, 8'h5A);
    chk(mode_active, 1'b1, "R5 qualifiers sampled at final key only");
    chk(perm_mass_erase, 1'b1, "R8 mass erase allowed when secure");
    chk(perm_read, 1'b0, "R8 read forbidden when secure");
    chk(perm_write, 1'b0, "R8 write forbidden when secure");
    chk(serial_irq_en, 1'b0, "R7 serial irq off while active");
    secure = 1'b0; idle(2);
    chk(perm_read, 1'b0, "R8 secure drop after entry ignored");
    pin_reset();
    chk(cpu_halt, 1'b0, "R7 halt released after reset");

    idle(2);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule